// File: doc/BRIEF.md
# Multi-Channel Counter Control Register Bank

This block is the host-side register bank for ten independent counter/timer channels. Each channel has a control register with a three-bit mode field and a count-direction bit. It also has a sixteen-bit constant register that holds the count the channel starts from, and a simple counter engine. A host writes the constant and the mode, pulses the channel's trigger, and then samples the running count through a read-back register. A shared stop register halts any group of channels with one write.

Bus accesses are word-addressed and carry a two-bit byte-lane enable. Lane value 2'b11 is a 16-bit access, 2'b01 is the low byte only and 2'b10 is the high byte only. Each register kind accepts only certain access widths. Read data is registered: it appears on `rdata` in the cycle after `rd_en` and is 0 in every other cycle.

Top module: `ctr_reg_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every mode, direction, constant and counter value is cleared, and `rdata` and `ch_active` go to 0.
- R2: The constant register of channel n is at word offset 0x20+n. A 16-bit write loads all 16 bits in one clock. A write with lane value 01 or 10 is discarded. A 16-bit read returns the stored value, and a narrower read returns 0.
- R3: While `soft_rst` is high at a clock edge, all ten constants are cleared. `soft_rst` leaves control registers and counters unchanged, and it wins over a same-cycle constant write.
- R4: The control register of channel n is at word offset 0x10+n. Bits 2:0 are the mode and bit 3 is the direction (1 = count down). Bits 15:4 read as 0. A write whose low lane is enabled updates bits 3:0. A write with only the high lane enabled leaves the register unchanged. A read with the low lane enabled returns the register, and any other read returns 0. `ch_active[n]` is high exactly when the mode of channel n is non-zero.
- R5: A trigger pulse on a channel whose mode is non-zero loads the counter with the constant at that clock edge. After that edge the counter steps by one on every clock, up or down according to the direction bit, and wraps modulo 2^16. A trigger while the mode is 0 has no effect.
- R6: While the mode is 0 the counter holds its value. Making the mode non-zero again does not resume counting until the next trigger.
- R7: A write to word offset 0x06 stops channels. Bit n of the write data (n = 0..9) selects channel n. Bits 7:0 act only when the low lane is enabled, and bits 9:8 act only when the high lane is enabled. Bits 15:10 are ignored. A selected channel's mode becomes 0 at that edge and its direction bit is kept. A 0 bit leaves its channel unchanged.
- R8: The stop register stores nothing, and any read of offset 0x06 returns 0.
- R9: The read-back register of channel n is at word offset 0x30+n. A 16-bit read returns the counter value held in the cycle of the read. A narrower read returns 0, and writes to it have no effect.
- R10: A stop in the same cycle as a trigger on that channel wins. The mode ends at 0, and the counter neither loads nor steps at that edge. A stop in a cycle where the channel is counting also suppresses that cycle's step.
- R11: A read of any word offset not named above returns 0. `rdata` is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous software clear of all constants |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 6 | Word offset of the access |
| be | input | 2 | Byte-lane enable: 11 = 16-bit, 01 = low byte, 10 = high byte |
| wdata | input | 16 | Write data |
| trig | input | 10 | Per-channel start pulse |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |
| ch_active | output | 10 | Per-channel flag, high while the mode is non-zero |

## Verification
The hardest case to reach is a stop strobe and a trigger on the same channel in the same clock. A single bus cannot issue a control write and a stop together, so the bench drives the trigger line alongside the stop-register write in one cycle. It then reads the counter back to show that the stale constant was not loaded. The wrap of the counter past 0xFFFF and below 0x0000 is reached by loading constants next to the boundary before triggering. Narrow accesses are run on every kind of register. A behavioural model checks `rdata` and `ch_active` on every clock.

// File: rtl/ctr_pkg.sv
// Package: shared sizes, register map offsets and the decoded bank type
// for the counter control register bank. Assumes word addressing with
// a six-bit offset and a four-bit channel index inside each bank.
package ctr_pkg;
    localparam int ADDR_W  = 6;
    localparam int IDX_W   = 4;
    localparam int DATA_W  = 16;
    localparam int LANE_W  = DATA_W / 8;
    localparam int MODE_W  = 3;
    localparam int CH_MAX  = 1 << IDX_W;

    localparam logic [ADDR_W-1:0] STOP_OFS   = 6'h06;
    localparam logic [ADDR_W-1:0] CTRL_BASE  = 6'h10;
    localparam logic [ADDR_W-1:0] CONST_BASE = 6'h20;
    localparam logic [ADDR_W-1:0] RDBK_BASE  = 6'h30;

    localparam logic [LANE_W-1:0] LANES_ALL  = '1;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_CTRL,
        BK_CONST,
        BK_RDBK,
        BK_STOP
    } bank_e;
endpackage

// File: rtl/ctr_bus_decode.sv
// Bus decoder: turns one host access into per-channel write strobes,
// stop strobes and a read selection. Assumes at most one access per
// cycle and that NUM_CH fits in one bank (NUM_CH <= 16).
module ctr_bus_decode
    import ctr_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANE_W-1:0]         be,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM_CH-1:0]         ctrl_we,
    output logic [NUM_CH-1:0]         const_we,
    output logic [NUM_CH-1:0]         stop_hit,
    output bank_e                     rd_bank,
    output logic [IDX_W-1:0]          rd_idx,
    output logic                      rd_full,
    output logic                      rd_low
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    bank_e            bank;
    logic [IDX_W-1:0] idx;
    logic             full;
    logic             stop_wr;

    assign idx  = addr[IDX_W-1:0];
    assign full = (be == LANES_ALL);

    // Classify the offset into a register bank, rejecting idle indices.
    always_comb begin
        bank = BK_NONE;
        if (addr == STOP_OFS) begin
            bank = BK_STOP;
        end else if (idx <= LAST_IDX) begin
            if (addr[ADDR_W-1:IDX_W] == CTRL_BASE[ADDR_W-1:IDX_W])
                bank = BK_CTRL;
            else if (addr[ADDR_W-1:IDX_W] == CONST_BASE[ADDR_W-1:IDX_W])
                bank = BK_CONST;
            else if (addr[ADDR_W-1:IDX_W] == RDBK_BASE[ADDR_W-1:IDX_W])
                bank = BK_RDBK;
        end
    end

    assign stop_wr = wr_en && (bank == BK_STOP);

    // Per-channel write and stop strobes; stop bits follow their byte lane.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_strobe
        assign ctrl_we[ch]  = wr_en && (bank == BK_CTRL) &&
                              (idx == IDX_W'(ch)) && be[0];
        assign const_we[ch] = wr_en && (bank == BK_CONST) &&
                              (idx == IDX_W'(ch)) && full;
        if (ch < DATA_W) begin : g_stop_bit
            assign stop_hit[ch] = stop_wr && be[ch / 8] && wdata[ch];
        end else begin : g_no_stop_bit
            assign stop_hit[ch] = 1'b0;
        end
    end

    assign rd_bank = rd_en ? bank : BK_NONE;
    assign rd_idx  = idx;
    assign rd_full = full;
    assign rd_low  = be[0];

    wire unused_dec = ^{wdata, be};
endmodule

// File: rtl/ctr_channel.sv
// One counter channel: control register (mode, direction), constant
// register and the up/down counter. Stop wins over a same-cycle control
// write and over a same-cycle trigger. Assumes single-cycle strobes.
module ctr_channel
    import ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ctrl_we,
    input  logic [MODE_W:0]   ctrl_wdata,
    input  logic              const_we,
    input  logic [DATA_W-1:0] const_wdata,
    input  logic              stop_hit,
    input  logic              trig,
    output logic [MODE_W-1:0] mode,
    output logic              down,
    output logic [DATA_W-1:0] konst,
    output logic [DATA_W-1:0] count
);
    logic running;
    logic enabled;
    logic start;
    logic step;

    assign enabled = (mode != '0);
    assign start   = trig && enabled && !stop_hit;
    assign step    = running && enabled && !stop_hit;

    // Control register: host write, then stop clears the mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
            down <= 1'b0;
        end else begin
            if (ctrl_we) begin
                mode <= ctrl_wdata[MODE_W-1:0];
                down <= ctrl_wdata[MODE_W];
            end
            if (stop_hit)
                mode <= '0;
        end
    end

    // Constant register: cleared by either reset, loaded by full writes.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            konst <= '0;
        else if (const_we)
            konst <= const_wdata;
    end

    // Counter: load on start, step while running and enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (start)
            count <= konst;
        else if (step)
            count <= down ? count - 1'b1 : count + 1'b1;
    end

    // Running flag: set by start, dropped by stop or a zero mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else if (start)
            running <= 1'b1;
        else if (stop_hit || !enabled)
            running <= 1'b0;
    end

    // R7
    stop_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> (mode == '0));

    // R5
    trig_loads_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && enabled && !stop_hit) |=> (count == $past(konst)));

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && enabled && !trig && !stop_hit) |=>
        (count == ($past(down) ? $past(count) - 16'd1 : $past(count) + 16'd1)));

    // R6
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> $stable(count));

    // R10
    stop_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> $stable(count));

    // R3
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (konst == '0));
endmodule

// File: rtl/ctr_read_mux.sv
// Read path: selects the addressed register, applies the width rule of
// its bank and registers the result, so read data follows one cycle
// after the strobe and is 0 otherwise. Assumes a pre-decoded bank.
module ctr_read_mux
    import ctr_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  bank_e                          rd_bank,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic                           rd_full,
    input  logic                           rd_low,
    input  logic [NUM_CH-1:0][MODE_W:0]    ctrl_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  const_all,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  count_all,
    output logic [DATA_W-1:0]              rdata
);
    logic [DATA_W-1:0] sel_data;

    // Pick the addressed value under its bank's access-width rule.
    always_comb begin
        sel_data = '0;
        unique case (rd_bank)
            BK_CTRL:  if (rd_low)  sel_data = DATA_W'(ctrl_all[rd_idx]);
            BK_CONST: if (rd_full) sel_data = const_all[rd_idx];
            BK_RDBK:  if (rd_full) sel_data = count_all[rd_idx];
            default:  sel_data = '0;
        endcase
    end

    // Register the read result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= sel_data;
    end

    // R9
    rdbk_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bank == BK_RDBK && rd_full) |=> (rdata == $past(count_all[rd_idx])));

    // R8
    stop_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bank == BK_STOP) |=> (rdata == '0));

    // R11
    no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bank == BK_NONE) |=> (rdata == '0));
endmodule

// File: rtl/ctr_reg_bank.sv
// Top of the counter control register bank: bus decoder, NUM_CH channel
// instances and the registered read path. Assumes one bus access per
// cycle, word addressing and synchronous active-low reset.
module ctr_reg_bank
    import ctr_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [LANE_W-1:0]     be,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_CH-1:0]     trig,
    output logic [DATA_W-1:0]     rdata,
    output logic [NUM_CH-1:0]     ch_active
);
    logic [NUM_CH-1:0]              ctrl_we;
    logic [NUM_CH-1:0]              const_we;
    logic [NUM_CH-1:0]              stop_hit;
    bank_e                          rd_bank;
    logic [IDX_W-1:0]               rd_idx;
    logic                           rd_full;
    logic                           rd_low;
    logic [NUM_CH-1:0][MODE_W:0]    ctrl_all;
    logic [NUM_CH-1:0][DATA_W-1:0]  const_all;
    logic [NUM_CH-1:0][DATA_W-1:0]  count_all;

    ctr_bus_decode #(.NUM_CH(NUM_CH)) i_decode (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .be       (be),
        .wdata    (wdata),
        .ctrl_we  (ctrl_we),
        .const_we (const_we),
        .stop_hit (stop_hit),
        .rd_bank  (rd_bank),
        .rd_idx   (rd_idx),
        .rd_full  (rd_full),
        .rd_low   (rd_low)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [MODE_W-1:0] mode;
        logic              down;

        ctr_channel i_channel (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_rst    (soft_rst),
            .ctrl_we     (ctrl_we[ch]),
            .ctrl_wdata  (wdata[MODE_W:0]),
            .const_we    (const_we[ch]),
            .const_wdata (wdata),
            .stop_hit    (stop_hit[ch]),
            .trig        (trig[ch]),
            .mode        (mode),
            .down        (down),
            .konst       (const_all[ch]),
            .count       (count_all[ch])
        );

        assign ctrl_all[ch]  = {down, mode};
        assign ch_active[ch] = (mode != '0);

        // R2
        const_narrow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == (CONST_BASE + ADDR_W'(ch)) && be != LANES_ALL && !soft_rst)
            |=> $stable(const_all[ch]));

        // R4
        ctrl_high_lane_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == (CTRL_BASE + ADDR_W'(ch)) && !be[0] && !stop_hit[ch])
            |=> $stable(ctrl_all[ch]));
    end

    ctr_read_mux #(.NUM_CH(NUM_CH)) i_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_bank   (rd_bank),
        .rd_idx    (rd_idx),
        .rd_full   (rd_full),
        .rd_low    (rd_low),
        .ctrl_all  (ctrl_all),
        .const_all (const_all),
        .count_all (count_all),
        .rdata     (rdata)
    );
endmodule

// File: tb/test_ctr_reg_bank.sv
module test_ctr_reg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0;
    logic [9:0]  trig = '0;
    logic [15:0] rdata;
    logic [9:0]  ch_active;

    int    checks = 0;
    int    failures = 0;
    bit    chk_en = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [2:0]  m_mode [10];
    logic        m_down [10];
    logic [15:0] m_k    [10];
    logic [15:0] m_c    [10];
    bit          m_run  [10];
    logic [15:0] m_rd;

    ctr_reg_bank i_ctr_reg_bank (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .be(be), .wdata(wdata), .trig(trig),
        .rdata(rdata), .ch_active(ch_active)
    );

    always #2.5 clk = ~clk;

    // reference model, updated at every rising edge
    always @(posedge clk) begin
        logic [15:0] nrd;
        if (!rst_n) begin
            for (int c = 0; c < 10; c++) begin
                m_mode[c] = 0; m_down[c] = 0; m_k[c] = 0; m_c[c] = 0; m_run[c] = 0;
            end
            m_rd = 0;
        end else begin
            nrd = 0;
            if (rd_en && addr[3:0] < 10) begin
                case (addr[5:4])
                    2'd1: if (be[0]) nrd = {12'd0, m_down[addr[3:0]], m_mode[addr[3:0]]};
                    2'd2: if (be == 2'b11) nrd = m_k[addr[3:0]];
                    2'd3: if (be == 2'b11) nrd = m_c[addr[3:0]];
                    default: nrd = 0;
                endcase
            end
            for (int c = 0; c < 10; c++) begin
                bit stp, st, go;
                stp = wr_en && addr == 6'h06 && ((c < 8) ? be[0] : be[1]) && wdata[c];
                st  = trig[c] && m_mode[c] != 0 && !stp;
                go  = m_run[c] && m_mode[c] != 0 && !stp;
                if (st) m_c[c] = m_k[c];
                else if (go) m_c[c] = m_down[c] ? m_c[c] - 16'd1 : m_c[c] + 16'd1;
                if (st) m_run[c] = 1;
                else if (stp || m_mode[c] == 0) m_run[c] = 0;
                if (wr_en && addr == 6'h10 + c && be[0]) begin
                    m_mode[c] = wdata[2:0];
                    m_down[c] = wdata[3];
                end
                if (stp) m_mode[c] = 0;
                if (soft_rst) m_k[c] = 0;
                else if (wr_en && addr == 6'h20 + c && be == 2'b11) m_k[c] = wdata;
            end
            m_rd = nrd;
        end
        chk_en = 1;
    end

    // compare outputs with the model away from the rising edge
    always @(negedge clk) begin
        logic [9:0] exp_act;
        if (chk_en && !done) begin
            for (int c = 0; c < 10; c++) exp_act[c] = (m_mode[c] != 0);
            checks++;
            if (rdata !== m_rd) begin
                failures++;
                $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata, m_rd, $time);
            end
            checks++;
            if (ch_active !== exp_act) begin
                failures++;
                $display("FAIL %s ch_active actual=%b expected=%b t=%0t", cur_req, ch_active, exp_act, $time);
            end
        end
    end

    // one bus cycle, called at a falling edge
    task automatic cyc(input bit w, input bit r, input logic [5:0] a,
                       input logic [1:0] b, input logic [15:0] d, input logic [9:0] t);
        wr_en = w; rd_en = r; addr = a; be = b; wdata = d; trig = t;
        @(negedge clk);
        wr_en = 0; rd_en = 0; addr = 0; be = 0; wdata = 0; trig = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [1:0] b, input logic [15:0] d);
        cyc(1, 0, a, b, d, 10'd0);
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] b);
        cyc(0, 1, a, b, 16'd0, 10'd0);
    endtask

    task automatic pulse(input logic [9:0] t);
        cyc(0, 0, 6'd0, 2'b00, 16'd0, t);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL %s watchdog expired", cur_req);
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        idle(3);
        rst_n = 1;
        rd(6'h20, 2'b11); rd(6'h10, 2'b11); rd(6'h30, 2'b11); idle(1);

        cur_req = "R2";
        for (int c = 0; c < 10; c++) wr(6'h20 + c, 2'b11, 16'h1000 + 16'(c) * 16'h0111);
        for (int c = 0; c < 10; c++) rd(6'h20 + c, 2'b11);
        wr(6'h22, 2'b01, 16'hABCD); wr(6'h22, 2'b10, 16'hABCD);
        rd(6'h22, 2'b11); rd(6'h22, 2'b01); rd(6'h22, 2'b10); idle(1);

        cur_req = "R11";
        rd(6'h00, 2'b11); rd(6'h1A, 2'b11); rd(6'h3F, 2'b11); rd(6'h07, 2'b11);
        rd(6'h2C, 2'b11); idle(2);

        cur_req = "R4";
        wr(6'h10, 2'b11, 16'h0001);
        wr(6'h11, 2'b01, 16'h000D);
        wr(6'h12, 2'b10, 16'h0007);
        wr(6'h13, 2'b11, 16'hFFFF);
        rd(6'h10, 2'b11); rd(6'h11, 2'b11); rd(6'h12, 2'b11); rd(6'h13, 2'b11);
        rd(6'h13, 2'b10); idle(1);

        cur_req = "R5";
        pulse(10'b00_0000_0011); idle(5);
        rd(6'h30, 2'b11); rd(6'h31, 2'b11);
        pulse(10'b00_0001_0000); idle(2); rd(6'h34, 2'b11);
        wr(6'h25, 2'b11, 16'hFFFE); wr(6'h15, 2'b11, 16'h0002);
        wr(6'h26, 2'b11, 16'h0001); wr(6'h16, 2'b11, 16'h000F);
        pulse(10'b00_0110_0000); idle(3);
        rd(6'h35, 2'b11); rd(6'h36, 2'b11);
        pulse(10'b00_0000_0001); rd(6'h30, 2'b11); idle(1);

        cur_req = "R9";
        rd(6'h31, 2'b01); rd(6'h31, 2'b10);
        wr(6'h31, 2'b11, 16'h5555); rd(6'h31, 2'b11);
        for (int k = 0; k < 4; k++) rd(6'h30, 2'b11);
        idle(1);

        cur_req = "R7";
        wr(6'h18, 2'b11, 16'h0003); wr(6'h19, 2'b11, 16'h000B);
        pulse(10'b11_0000_0000); idle(2);
        wr(6'h06, 2'b11, 16'h0000); idle(2);
        wr(6'h06, 2'b10, 16'hFFFF); idle(1);
        rd(6'h18, 2'b11); rd(6'h19, 2'b11); rd(6'h38, 2'b11); rd(6'h10, 2'b11);
        wr(6'h06, 2'b01, 16'hFC02); idle(1);
        rd(6'h11, 2'b11); rd(6'h31, 2'b11); rd(6'h30, 2'b11); idle(2);

        cur_req = "R8";
        rd(6'h06, 2'b11); rd(6'h06, 2'b01); wr(6'h06, 2'b11, 16'h0000); rd(6'h06, 2'b11);
        idle(1);

        cur_req = "R6";
        wr(6'h10, 2'b11, 16'h0000); idle(3); rd(6'h30, 2'b11);
        pulse(10'b00_0000_0001); rd(6'h30, 2'b11);
        wr(6'h10, 2'b11, 16'h0004); idle(3); rd(6'h30, 2'b11);
        pulse(10'b00_0000_0001); idle(3); rd(6'h30, 2'b11); idle(1);

        cur_req = "R10";
        wr(6'h27, 2'b11, 16'h7777); wr(6'h17, 2'b11, 16'h0001);
        cyc(1, 0, 6'h06, 2'b01, 16'h0080, 10'b00_1000_0000);
        idle(2); rd(6'h37, 2'b11); rd(6'h17, 2'b11);
        cyc(1, 0, 6'h06, 2'b01, 16'h0001, 10'd0);
        rd(6'h30, 2'b11); idle(2); rd(6'h30, 2'b11); idle(1);

        cur_req = "R3";
        cyc(1, 0, 6'h24, 2'b11, 16'h4444, 10'd0);
        soft_rst = 1; wr(6'h23, 2'b11, 16'h9999); soft_rst = 0;
        for (int c = 0; c < 10; c++) rd(6'h20 + c, 2'b11);
        rd(6'h11, 2'b11); rd(6'h35, 2'b11); idle(2);

        cur_req = "R1";
        rst_n = 0; idle(2); rst_n = 1;
        rd(6'h11, 2'b11); rd(6'h25, 2'b11); rd(6'h35, 2'b11); idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule